// File: doc/BRIEF.md
# Interval Timer Peripheral

A 32-bit down-counting interval timer behind a small word-addressed register bus, with a single level-sensitive interrupt line. Software loads a 32-bit interval as two 16-bit halves, starts and halts the count with strobe bits, selects free-running reload or a single interval, and gates the interrupt. A timeout is signalled by a sticky flag that software removes by writing the status register with any value.

The running count is not readable directly. A write to either capture register freezes a copy of the live count, which software then reads as two halves with no risk of tearing while the counter keeps moving. Reads are combinational from the address; writes take effect on the rising clock edge while the write enable is high. The bus carries 16 data bits, which covers every register field.

Top module: `interval_timer`

## Requirements
- R1: After reset the status reads 0, the control reads 0, both interval halves read 0xFFFF and `irq` is low.
- R2: Offset 2 holds interval bits 15:0 and offset 3 holds interval bits 31:16; each reads back what was last written to it.
- R3: A write to offset 2 or 3 halts the counter (status bit 1 becomes 0) and loads the count with the whole new 32-bit interval.
- R4: A write to offset 1 with bit 2 set starts the counter (status bit 1 reads 1); the count drops by one per clock and status bit 0 (timeout) becomes 1 on the (interval+1)-th rising edge after the start write.
- R5: A write to offset 0 with any data clears status bit 0, unless a new timeout occurs on the same edge.
- R6: `irq` is high exactly while status bit 0 is 1 and control bit 0 (interrupt enable) is 1.
- R7: With control bit 1 set, a timeout reloads the interval and the counter keeps running, giving a timeout every interval+1 clocks.
- R8: With control bit 1 clear, the counter halts after its first timeout, status bit 1 returns to 0 and the count is reloaded with the interval.
- R9: A write to offset 4 or 5 captures the live count; offset 4 then reads bits 15:0 and offset 5 bits 31:16 of that capture, unchanged while the counter runs.
- R10: A write to offset 1 with bit 3 set halts the counter; when bits 2 and 3 are set in the same write the counter stays halted.
- R11: Control bits 2 and 3 read back as 0, bits 0 and 1 read back as last written, and offsets 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write enable, sampled on the rising edge |
| bus_addr | input | 3 | Word offset of the register accessed |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong count shows at the ports as a timeout flag that rises one or more edges early or late, so the bench polls status on every cycle around the expected edge and names the exact edge. A stale run state shows as a second timeout that should never come in single-interval mode, or a missing one in free-running mode, within one interval. A count that was not reloaded by an interval write shows through the capture registers on the next capture, a few cycles later.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int HALF_W = 16;
    localparam int CNT_W  = 2 * HALF_W;
    localparam int ADDR_W = 3;

    // Register offsets
    typedef enum logic [ADDR_W-1:0] {
        A_STATUS  = 3'd0,
        A_CTRL    = 3'd1,
        A_PER_LO  = 3'd2,
        A_PER_HI  = 3'd3,
        A_SNAP_LO = 3'd4,
        A_SNAP_HI = 3'd5
    } reg_addr_e;

    // Control bit positions
    localparam int CB_IEN   = 0;
    localparam int CB_CONT  = 1;
    localparam int CB_START = 2;
    localparam int CB_STOP  = 3;
    localparam int CTL_BITS = 4;

    // Status bit positions
    localparam int SB_FLAG = 0;
    localparam int SB_RUN  = 1;

    typedef struct packed {
        logic cont;
        logic ien;
    } ctl_t;

    typedef struct packed {
        logic st_clr;
        logic ctl_wr;
        logic per_lo;
        logic per_hi;
        logic snap;
        logic start;
        logic stop;
    } wr_t;

    function automatic logic [HALF_W-1:0] half_of(input logic [CNT_W-1:0] v,
                                                  input logic upper);
        return upper ? v[CNT_W-1:HALF_W] : v[HALF_W-1:0];
    endfunction

endpackage

// File: rtl/ivt_decode.sv
module ivt_decode
    import ivt_pkg::*;
(
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [CTL_BITS-1:0] ctl_bits,
    output wr_t                 w
);
    always_comb begin
        w = '0;
        if (wr_en) begin
            case (reg_addr_e'(addr))
                A_STATUS:  w.st_clr = 1'b1;
                A_CTRL: begin
                    w.ctl_wr = 1'b1;
                    w.start  = ctl_bits[CB_START];
                    w.stop   = ctl_bits[CB_STOP];
                end
                A_PER_LO:  w.per_lo = 1'b1;
                A_PER_HI:  w.per_hi = 1'b1;
                A_SNAP_LO,
                A_SNAP_HI: w.snap   = 1'b1;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/ivt_core.sv
module ivt_core
    import ivt_pkg::*;
#(
    parameter int HW = HALF_W,
    localparam int CW = 2 * HW
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_t           w,
    input  logic [HW-1:0] wdata,
    output logic [CW-1:0] period_q,
    output logic [CW-1:0] cnt_q,
    output logic          run_q,
    output logic          flag_q,
    output ctl_t          ctl_q
);
    logic          per_wr;
    logic          tick;
    logic          hit;
    logic [CW-1:0] period_nx;

    always_comb begin
        per_wr    = w.per_lo | w.per_hi;
        tick      = run_q & ~per_wr;
        hit       = tick & (cnt_q == '0);
        period_nx = period_q;
        if (w.per_lo) period_nx[HW-1:0]  = wdata;
        if (w.per_hi) period_nx[CW-1:HW] = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= '1;
            cnt_q    <= '1;
            run_q    <= 1'b0;
            flag_q   <= 1'b0;
            ctl_q    <= '0;
        end else begin
            // a new timeout beats a clear on the same edge
            if (w.st_clr) flag_q <= 1'b0;
            if (hit)      flag_q <= 1'b1;

            period_q <= period_nx;

            if (per_wr) begin
                cnt_q <= period_nx;
                run_q <= 1'b0;
            end else if (hit) begin
                cnt_q <= period_q;
                if (!ctl_q.cont) run_q <= 1'b0;
            end else if (tick) begin
                cnt_q <= cnt_q - 1'b1;
            end

            if (w.ctl_wr) begin
                ctl_q.ien  <= wdata[CB_IEN];
                ctl_q.cont <= wdata[CB_CONT];
                if (w.stop)       run_q <= 1'b0;
                else if (w.start) run_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ivt_snap.sv
module ivt_snap #(
    parameter int CW = ivt_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic [CW-1:0] cnt,
    output logic [CW-1:0] snap_q
);
    always_ff @(posedge clk) begin
        if (rst)       snap_q <= '1;
        else if (take) snap_q <= cnt;
    end
endmodule

// File: rtl/ivt_rdmux.sv
module ivt_rdmux
    import ivt_pkg::*;
#(
    parameter int HW = HALF_W,
    localparam int CW = 2 * HW
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              run,
    input  logic              flag,
    input  ctl_t              ctl,
    input  logic [CW-1:0]     period,
    input  logic [CW-1:0]     snap,
    output logic [HW-1:0]     rdata
);
    always_comb begin
        rdata = '0;
        case (reg_addr_e'(addr))
            A_STATUS: begin
                rdata[SB_FLAG] = flag;
                rdata[SB_RUN]  = run;
            end
            A_CTRL: begin
                rdata[CB_IEN]  = ctl.ien;
                rdata[CB_CONT] = ctl.cont;
            end
            A_PER_LO:  rdata = half_of(period, 1'b0);
            A_PER_HI:  rdata = half_of(period, 1'b1);
            A_SNAP_LO: rdata = half_of(snap, 1'b0);
            A_SNAP_HI: rdata = half_of(snap, 1'b1);
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import ivt_pkg::*;
#(
    parameter int HW = HALF_W,
    localparam int CW = 2 * HW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [HW-1:0]     bus_wdata,
    output logic [HW-1:0]     bus_rdata,
    output logic              irq
);
    wr_t           w;
    logic [CW-1:0] period_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] snap_q;
    logic          run_q;
    logic          flag_q;
    ctl_t          ctl_q;

    ivt_decode u_dec (
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .ctl_bits (bus_wdata[CTL_BITS-1:0]),
        .w        (w)
    );

    ivt_core #(.HW(HW)) u_core (
        .clk      (clk),
        .rst      (rst),
        .w        (w),
        .wdata    (bus_wdata),
        .period_q (period_q),
        .cnt_q    (cnt_q),
        .run_q    (run_q),
        .flag_q   (flag_q),
        .ctl_q    (ctl_q)
    );

    ivt_snap #(.CW(CW)) u_snap (
        .clk    (clk),
        .rst    (rst),
        .take   (w.snap),
        .cnt    (cnt_q),
        .snap_q (snap_q)
    );

    ivt_rdmux #(.HW(HW)) u_rd (
        .addr   (bus_addr),
        .run    (run_q),
        .flag   (flag_q),
        .ctl    (ctl_q),
        .period (period_q),
        .snap   (snap_q),
        .rdata  (bus_rdata)
    );

    assign irq = flag_q & ctl_q.ien;
endmodule

// File: rtl/ivt_checker.sv
module ivt_checker #(
    parameter int CW = ivt_pkg::CNT_W
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [2:0]    addr,
    input logic          stop_bit,
    input logic          irq,
    input logic          run,
    input logic          flag,
    input logic [CW-1:0] cnt,
    input logic          cont
);
    assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
        (run && !wr_en && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd0 && !(run && cnt == '0)) |=> !flag);

    assert_irq_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (irq && !wr_en) |=> irq);

    assert_period_halt_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == 3'd2 || addr == 3'd3)) |=> !run);

    assert_free_run_R7: assert property (@(posedge clk) disable iff (rst)
        (run && cnt == '0 && cont && !wr_en) |=> (run && flag));

    assert_single_R8: assert property (@(posedge clk) disable iff (rst)
        (run && cnt == '0 && !cont && !wr_en) |=> (!run && flag));

    assert_stop_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd1 && stop_bit) |=> !run);
endmodule

bind interval_timer ivt_checker #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_wr),
    .addr     (bus_addr),
    .stop_bit (bus_wdata[3]),
    .irq      (irq),
    .run      (run_q),
    .flag     (flag_q),
    .cnt      (cnt_q),
    .cont     (ctl_q.cont)
);

// File: tb/interval_timer_tb.sv
module interval_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [2:0]  a;
        logic [15:0] d;
        logic        i;
        int          r;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    interval_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // monitor: compares mid-low-phase against the scoreboard
    always @(negedge clk) begin
        #5;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (bus_rdata !== e.d || irq !== e.i) begin
                bad++;
                $display("FAIL R%0d addr=%0d rdata=%h exp=%h irq=%b exp_irq=%b",
                         e.r, e.a, bus_rdata, e.d, irq, e.i);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [15:0] d,
                      input logic i, input int r);
        exp_t e;
        @(negedge clk);
        bus_addr = a;
        e.a = a; e.d = d; e.i = i; e.r = r;
        sb.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        // R1 reset state
        rd(0, 16'h0000, 0, 1);
        rd(1, 16'h0000, 0, 1);
        rd(2, 16'hFFFF, 0, 1);
        rd(3, 16'hFFFF, 0, 1);
        // R2 interval halves
        wr(2, 16'd5);
        wr(3, 16'd0);
        rd(2, 16'd5, 0, 2);
        rd(3, 16'd0, 0, 2);
        // R4 start, free-running, irq enabled
        wr(1, 16'h0007);
        rd(1, 16'h0003, 0, 11);            // R11 strobes read 0
        rd(0, 16'h0002, 0, 4);             // R4 running
        rd(0, 16'h0002, 0, 4);
        rd(0, 16'h0002, 0, 4);
        rd(0, 16'h0002, 0, 4);             // count at 0, no timeout yet
        rd(0, 16'h0003, 1, 4);             // R4 timeout on 6th edge, R6 irq
        wr(0, 16'h0000);
        rd(0, 16'h0002, 0, 5);             // R5 cleared
        rd(0, 16'h0002, 0, 7);
        rd(0, 16'h0002, 0, 7);
        rd(0, 16'h0003, 1, 7);             // R7 second timeout 6 edges later
        // R9 capture while running
        wr(4, 16'h0000);
        rd(4, 16'd4, 1, 9);
        rd(5, 16'd0, 1, 9);
        rd(4, 16'd4, 1, 9);                // R9 stable
        // R10 stop, then clear
        wr(1, 16'h0008);
        wr(0, 16'h0000);
        rd(0, 16'h0000, 0, 10);
        rd(1, 16'h0000, 0, 11);
        wr(1, 16'h000C);
        rd(0, 16'h0000, 0, 10);            // R10 stop wins over start
        // R3 interval write halts and reloads
        wr(2, 16'd3);
        wr(1, 16'h0004);
        wr(3, 16'd0);
        rd(0, 16'h0000, 0, 3);
        wr(4, 16'h0000);
        rd(4, 16'd3, 0, 3);
        idle(5);
        wr(5, 16'h0000);
        rd(4, 16'd3, 0, 3);
        // R8 single interval
        wr(1, 16'h0005);
        rd(0, 16'h0002, 0, 8);
        rd(0, 16'h0002, 0, 8);
        rd(0, 16'h0002, 0, 8);
        rd(0, 16'h0001, 1, 8);
        idle(6);
        rd(0, 16'h0001, 1, 8);             // R8 no further run
        wr(4, 16'h0000);
        rd(4, 16'd3, 1, 8);                // R8 reloaded
        // R6 irq gating
        wr(1, 16'h0000);
        rd(0, 16'h0001, 0, 6);
        wr(1, 16'h0001);
        rd(0, 16'h0001, 1, 6);
        // R2 / R3 upper half
        wr(3, 16'h0001);
        rd(3, 16'h0001, 1, 2);
        rd(2, 16'h0003, 1, 2);
        wr(4, 16'h0000);
        rd(5, 16'h0001, 1, 3);
        rd(4, 16'h0003, 1, 3);
        // R5 any data clears
        wr(0, 16'h5A5A);
        rd(0, 16'h0000, 0, 5);
        // R11 unused offsets
        rd(6, 16'h0000, 0, 11);
        rd(7, 16'h0000, 0, 11);
        idle(3);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule